// File: doc/BRIEF.md
# SD Card SPI-Mode Bring-Up Sequencer

This block walks a freshly powered SD card from its native mode into SPI-mode block transfer. It sits beside a byte-level command engine. For each step it presents a command index and a 32-bit argument with a one-cycle start strobe, then waits for the engine to return the card's R1 status byte or a timeout flag. It also asks the engine for idle filler bytes, drives chip select, and picks between the slow identification clock and the fast transfer clock.

After a start request, the sequencer sends a run of filler bytes with chip select high. It then resets the card and probes its interface condition. That probe decides which of two operating-condition polling loops runs: the legacy loop or the high-capacity loop. The high-capacity loop inserts a programmable idle gap before every attempt. The sequencer then fixes the block length to 512 bytes and reports the result. The result is a card type code and a flag that says whether block numbers must be multiplied by 512 to form card addresses.

Type codes are 0 for failure, 1 for a legacy card and 2 for a second-generation card. Code 3 is reserved for high capacity. The sequencer never produces code 3, because it only sees R1 bytes. The result and the clock choice hold until the next start request is accepted.

Top module: `sd_init_seq`

## Requirements
- R1: Out of reset, card_type is 0, addr_scale is 0, fast_clk is 0, init_done is 0, cs_n is 1, and neither cmd_start nor dummy_req is high.
- R2: After init_req is accepted, exactly PRE_BYTES filler-byte requests are issued before the first command. cs_n is high and fast_clk is 0 during each of them.
- R3: The first command is index 0 with argument 0. Unless its R1 is exactly 0x01 with no timeout, the run ends as a failure.
- R4: The second command is index 8 with argument 0x000001AA. An R1 of 0x01 selects the second-generation path. An R1 of 0x05 selects the legacy path. Any other value, or a timeout, is a failure. Commands 55 and 58 carry argument 0 and their responses are not judged.
- R5: The legacy path repeats command 55 then command 41 with argument 0 until command 41 returns 0x00. It then reports card_type 1 and addr_scale 1.
- R6: On the second-generation path, each attempt issues command 58, command 55, then command 41 with argument 0x40000000. At least WAIT_CYCLES clock cycles separate the preceding response (index 8 or a failed index 41) from the start of command 58. Success reports card_type 2 and addr_scale 0.
- R7: At most MAX_TRIES command-41 attempts are made. A ready answer on the last allowed attempt counts as success. Exhausting the attempts reports failure.
- R8: After identification, command 16 with argument 512 is sent. A non-zero R1 or a timeout is a failure. fast_clk rises only together with a successful result and is 0 while any command of the sequence is issued.
- R9: init_done is a one-cycle pulse. card_type, addr_scale and fast_clk change only with that pulse or when a new init_req is accepted, which clears all three. On failure all three are 0.
- R10: init_req is ignored while a sequence is in progress.
- R11: cmd_start is a one-cycle pulse. cmd_idx and cmd_arg hold until cmd_done, and cs_n is low from cmd_start through cmd_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Start a bring-up sequence (taken when idle) |
| cmd_start | output | 1 | One-cycle strobe: issue the presented command |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Command engine finished; response valid this cycle |
| cmd_r1 | input | 8 | R1 status byte returned by the card |
| cmd_timeout | input | 1 | No response arrived within the engine's limit |
| dummy_req | output | 1 | One-cycle strobe: clock out one 0xFF filler byte |
| dummy_done | input | 1 | Filler byte finished |
| cs_n | output | 1 | Card chip select, active low |
| fast_clk | output | 1 | 0 selects the slow identification clock, 1 the transfer clock |
| card_type | output | 2 | 0 fail, 1 legacy, 2 second generation, 3 reserved |
| addr_scale | output | 1 | 1 when block numbers must be multiplied by 512 |
| init_done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The attempt limit and a ready answer can land in the same cycle. On the final allowed command-41 attempt, the cycle that judges the response is also the cycle in which the attempt counter reports its last value, so success and give-up compete for the next state. The card model is set to answer ready exactly on attempt MAX_TRIES on both paths. The bench expects a successful card type, exactly MAX_TRIES command-41 issues and a following command 16. Neighbouring cases never answer ready, and there the bench expects failure after the same count.

// File: rtl/sd_init_pkg.sv
`timescale 1ns/1ps
package sd_init_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_PRE_W,
        PH_CMD,
        PH_CMD_W,
        PH_GAP
    } phase_t;

    typedef enum logic [2:0] {
        STP_RESET,
        STP_IFCOND,
        STP_V1_APP,
        STP_V1_OP,
        STP_V2_OCR,
        STP_V2_APP,
        STP_V2_OP,
        STP_BLKLEN
    } step_t;

    typedef enum logic [1:0] {
        CARD_NONE = 2'd0,
        CARD_V1   = 2'd1,
        CARD_V2   = 2'd2,
        CARD_V2HC = 2'd3
    } card_t;

    typedef enum logic [1:0] {
        OC_ADVANCE,
        OC_BRANCH,
        OC_RETRY,
        OC_FAIL
    } outcome_t;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
    } cmd_req_t;

    localparam logic [7:0]  R1_READY        = 8'h00;
    localparam logic [7:0]  R1_IDLE         = 8'h01;
    localparam logic [7:0]  R1_IDLE_ILLEGAL = 8'h05;

    localparam logic [31:0] ARG_NONE   = 32'h0000_0000;
    localparam logic [31:0] ARG_IFCOND = 32'h0000_01AA;
    localparam logic [31:0] ARG_HCS    = 32'h4000_0000;
    localparam logic [31:0] ARG_BLKLEN = 32'd512;

    // Command presented for each step of the sequence.
    function automatic cmd_req_t step_cmd(input step_t s);
        cmd_req_t c;
        case (s)
            STP_RESET:  begin c.idx = 6'd0;  c.arg = ARG_NONE;   end
            STP_IFCOND: begin c.idx = 6'd8;  c.arg = ARG_IFCOND; end
            STP_V1_APP: begin c.idx = 6'd55; c.arg = ARG_NONE;   end
            STP_V1_OP:  begin c.idx = 6'd41; c.arg = ARG_NONE;   end
            STP_V2_OCR: begin c.idx = 6'd58; c.arg = ARG_NONE;   end
            STP_V2_APP: begin c.idx = 6'd55; c.arg = ARG_NONE;   end
            STP_V2_OP:  begin c.idx = 6'd41; c.arg = ARG_HCS;    end
            STP_BLKLEN: begin c.idx = 6'd16; c.arg = ARG_BLKLEN; end
            default:    begin c.idx = 6'd0;  c.arg = ARG_NONE;   end
        endcase
        return c;
    endfunction

    // True when a response arrived and carries exactly the wanted byte.
    function automatic logic r1_is(input logic [7:0] r1, input logic tmo,
                                   input logic [7:0] want);
        return !tmo && (r1 == want);
    endfunction

endpackage

// File: rtl/sd_limit_ctr.sv
`timescale 1ns/1ps
module sd_limit_ctr #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_last = (cnt == LAST);

    // R7
    ctr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |-> !at_last);

endmodule

// File: rtl/sd_step_decode.sv
`timescale 1ns/1ps
module sd_step_decode
    import sd_init_pkg::*;
(
    input  step_t      step,
    input  logic [7:0] r1,
    input  logic       tmo,
    input  logic       try_last,
    output cmd_req_t   req,
    output outcome_t   outcome
);
    logic is_idle, is_idle_ill, is_ready;

    assign req         = step_cmd(step);
    assign is_idle     = r1_is(r1, tmo, R1_IDLE);
    assign is_idle_ill = r1_is(r1, tmo, R1_IDLE_ILLEGAL);
    assign is_ready    = r1_is(r1, tmo, R1_READY);

    always_comb begin
        outcome = OC_FAIL;
        case (step)
            STP_RESET:  outcome = is_idle ? OC_ADVANCE : OC_FAIL;
            STP_IFCOND: begin
                if (is_idle)          outcome = OC_ADVANCE;
                else if (is_idle_ill) outcome = OC_BRANCH;
                else                  outcome = OC_FAIL;
            end
            STP_V1_APP, STP_V2_OCR, STP_V2_APP: outcome = OC_ADVANCE;
            STP_V1_OP, STP_V2_OP: begin
                if (is_ready)      outcome = OC_ADVANCE;
                else if (try_last) outcome = OC_FAIL;
                else               outcome = OC_RETRY;
            end
            STP_BLKLEN: outcome = is_ready ? OC_ADVANCE : OC_FAIL;
            default:    outcome = OC_FAIL;
        endcase
    end

endmodule

// File: rtl/sd_init_seq.sv
`timescale 1ns/1ps
module sd_init_seq
    import sd_init_pkg::*;
#(
    parameter int unsigned PRE_BYTES   = 16,
    parameter int unsigned MAX_TRIES   = 5000,
    parameter int unsigned WAIT_CYCLES = 6250000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        init_req,
    output logic        cmd_start,
    output logic [5:0]  cmd_idx,
    output logic [31:0] cmd_arg,
    input  logic        cmd_done,
    input  logic [7:0]  cmd_r1,
    input  logic        cmd_timeout,
    output logic        dummy_req,
    input  logic        dummy_done,
    output logic        cs_n,
    output logic        fast_clk,
    output logic [1:0]  card_type,
    output logic        addr_scale,
    output logic        init_done
);
    phase_t   phase;
    step_t    step;
    card_t    pend_type;
    card_t    type_q;
    logic     pend_scale;
    cmd_req_t req;
    outcome_t outcome;

    logic accept, judge;
    logic byte_last, byte_inc;
    logic try_last, try_inc;
    logic gap_last, gap_inc, gap_clr;

    assign accept   = (phase == PH_IDLE) && init_req;
    assign judge    = (phase == PH_CMD_W) && cmd_done;
    assign byte_inc = (phase == PH_PRE_W) && dummy_done && !byte_last;
    assign try_inc  = judge && (outcome == OC_RETRY);
    assign gap_clr  = (phase != PH_GAP);
    assign gap_inc  = (phase == PH_GAP) && !gap_last;

    sd_limit_ctr #(.LIMIT(PRE_BYTES)) u_bytes (
        .clk(clk), .rst(rst), .clr(accept), .inc(byte_inc), .at_last(byte_last)
    );

    sd_limit_ctr #(.LIMIT(MAX_TRIES)) u_tries (
        .clk(clk), .rst(rst), .clr(accept), .inc(try_inc), .at_last(try_last)
    );

    sd_limit_ctr #(.LIMIT(WAIT_CYCLES)) u_gap (
        .clk(clk), .rst(rst), .clr(gap_clr), .inc(gap_inc), .at_last(gap_last)
    );

    sd_step_decode u_decode (
        .step(step), .r1(cmd_r1), .tmo(cmd_timeout), .try_last(try_last),
        .req(req), .outcome(outcome)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            step       <= STP_RESET;
            pend_type  <= CARD_NONE;
            pend_scale <= 1'b0;
            type_q     <= CARD_NONE;
            addr_scale <= 1'b0;
            fast_clk   <= 1'b0;
            init_done  <= 1'b0;
        end else begin
            init_done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (init_req) begin
                        phase      <= PH_PRE;
                        step       <= STP_RESET;
                        type_q     <= CARD_NONE;
                        addr_scale <= 1'b0;
                        fast_clk   <= 1'b0;
                    end
                end
                PH_PRE:   phase <= PH_PRE_W;
                PH_PRE_W: begin
                    if (dummy_done) phase <= byte_last ? PH_CMD : PH_PRE;
                end
                PH_CMD:   phase <= PH_CMD_W;
                PH_GAP: begin
                    if (gap_last) phase <= PH_CMD;
                end
                PH_CMD_W: begin
                    if (cmd_done) begin
                        case (outcome)
                            OC_FAIL: begin
                                phase      <= PH_IDLE;
                                init_done  <= 1'b1;
                                type_q     <= CARD_NONE;
                                addr_scale <= 1'b0;
                                fast_clk   <= 1'b0;
                            end
                            OC_BRANCH: begin
                                step  <= STP_V1_APP;
                                phase <= PH_CMD;
                            end
                            OC_RETRY: begin
                                if (step == STP_V1_OP) begin
                                    step  <= STP_V1_APP;
                                    phase <= PH_CMD;
                                end else begin
                                    step  <= STP_V2_OCR;
                                    phase <= PH_GAP;
                                end
                            end
                            default: begin
                                phase <= PH_CMD;
                                case (step)
                                    STP_RESET:  step <= STP_IFCOND;
                                    STP_IFCOND: begin
                                        step  <= STP_V2_OCR;
                                        phase <= PH_GAP;
                                    end
                                    STP_V1_APP: step <= STP_V1_OP;
                                    STP_V1_OP: begin
                                        pend_type  <= CARD_V1;
                                        pend_scale <= 1'b1;
                                        step       <= STP_BLKLEN;
                                    end
                                    STP_V2_OCR: step <= STP_V2_APP;
                                    STP_V2_APP: step <= STP_V2_OP;
                                    STP_V2_OP: begin
                                        pend_type  <= CARD_V2;
                                        pend_scale <= 1'b0;
                                        step       <= STP_BLKLEN;
                                    end
                                    default: begin
                                        phase      <= PH_IDLE;
                                        init_done  <= 1'b1;
                                        type_q     <= pend_type;
                                        addr_scale <= pend_scale;
                                        fast_clk   <= 1'b1;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign cmd_start = (phase == PH_CMD);
    assign dummy_req = (phase == PH_PRE);
    assign cs_n      = !((phase == PH_CMD) || (phase == PH_CMD_W));
    assign cmd_idx   = req.idx;
    assign cmd_arg   = req.arg;
    assign card_type = type_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> !init_done);

    // R9
    type_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!init_done && !$past(accept)) |-> $stable(card_type));

    // R8
    fast_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fast_clk) |-> (init_done && card_type != 2'd0));

    // R8
    slow_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> !fast_clk);

    // R2
    pre_cs_chk: assert property (@(posedge clk) disable iff (rst)
        dummy_req |-> (cs_n && !fast_clk));

endmodule

// File: tb/sd_init_seq_bench.sv
`timescale 1ns/1ps
module sd_init_seq_bench;
    localparam int PRE   = 16;
    localparam int TRIES = 6;
    localparam int GAPC  = 20;

    typedef struct packed {
        logic [7:0] r0;
        logic [7:0] r8;
        logic [3:0] ok_at;
        logic [7:0] r16;
        logic [1:0] typ;
        logic       scale;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h01, 4'd1, 8'h00, 2'd2, 1'b0, 4'd6},  // R6 ready first try
        '{8'h01, 8'h05, 4'd3, 8'h00, 2'd1, 1'b1, 4'd5},  // R5 ready third try
        '{8'h00, 8'h01, 4'd1, 8'h00, 2'd0, 1'b0, 4'd3},  // R3 not idle
        '{8'h03, 8'h01, 4'd1, 8'h00, 2'd0, 1'b0, 4'd3},  // R3 extra bit
        '{8'h01, 8'h04, 4'd1, 8'h00, 2'd0, 1'b0, 4'd4},  // R4 bad probe
        '{8'h01, 8'h01, 4'd6, 8'h00, 2'd2, 1'b0, 4'd7},  // R7 last attempt v2
        '{8'h01, 8'h05, 4'd0, 8'h00, 2'd0, 1'b0, 4'd7},  // R7 exhaust v1
        '{8'h01, 8'h01, 4'd2, 8'h04, 2'd0, 1'b0, 4'd8},  // R8 block length refused
        '{8'h01, 8'h05, 4'd6, 8'h00, 2'd1, 1'b1, 4'd7},  // R7 last attempt v1
        '{8'h01, 8'h01, 4'd0, 8'h00, 2'd0, 1'b0, 4'd7}   // R7 exhaust v2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_req = 1'b0;
    logic        cmd_start;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic        cmd_done = 1'b0;
    logic [7:0]  cmd_r1 = 8'hFF;
    logic        cmd_timeout = 1'b0;
    logic        dummy_req;
    logic        dummy_done = 1'b0;
    logic        cs_n;
    logic        fast_clk;
    logic [1:0]  card_type;
    logic        addr_scale;
    logic        init_done;

    always #4 clk = ~clk;

    sd_init_seq #(.PRE_BYTES(PRE), .MAX_TRIES(TRIES), .WAIT_CYCLES(GAPC)) u_sd_init_seq (
        .clk(clk), .rst(rst), .init_req(init_req),
        .cmd_start(cmd_start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_done(cmd_done), .cmd_r1(cmd_r1), .cmd_timeout(cmd_timeout),
        .dummy_req(dummy_req), .dummy_done(dummy_done), .cs_n(cs_n),
        .fast_clk(fast_clk), .card_type(card_type), .addr_scale(addr_scale),
        .init_done(init_done)
    );

    int checks = 0;
    int bad = 0;

    // card model configuration (written by the main sequence)
    logic [7:0] m_r0 = 8'h01, m_r8 = 8'h01, m_r16 = 8'h00;
    int         m_ok = 1;
    logic       m_to0 = 1'b0;
    logic       clr_req = 1'b0;

    // model statistics (written by the model only)
    int n_dummy, dummy_bad, n_acmd, n_16, arg_bad, hs_bad, clk_bad, n_cmd, n_done;
    int min_gap, last_end, cyc;
    int logv [0:63];

    initial begin : card_model
        logic       c_pend, d_pend, c_to;
        int         c_dly;
        logic [5:0] c_idx;
        logic [31:0] c_arg, exp_arg;
        logic [7:0] c_r1;
        c_pend = 0; d_pend = 0; c_dly = 0; c_to = 0; c_idx = 0; c_arg = 0; c_r1 = 0;
        cyc = 0; n_dummy = 0; dummy_bad = 0; n_acmd = 0; n_16 = 0; arg_bad = 0;
        hs_bad = 0; clk_bad = 0; n_cmd = 0; n_done = 0; min_gap = 1000000; last_end = 0;
        forever begin
            @(negedge clk);
            cyc++;
            cmd_done = 1'b0;
            dummy_done = 1'b0;
            cmd_timeout = 1'b0;
            if (clr_req) begin
                n_dummy = 0; dummy_bad = 0; n_acmd = 0; n_16 = 0; arg_bad = 0;
                hs_bad = 0; clk_bad = 0; n_cmd = 0; n_done = 0; min_gap = 1000000;
                for (int i = 0; i < 64; i++) logv[i] = -1;
            end
            if (init_done) n_done++;
            if (d_pend) begin
                dummy_done = 1'b1;
                d_pend = 1'b0;
            end
            if (dummy_req) begin
                n_dummy++;
                if (cs_n !== 1'b1 || fast_clk !== 1'b0 || n_cmd != 0) dummy_bad++;
                d_pend = 1'b1;
            end
            if (c_pend) begin
                c_dly--;
                if (c_dly == 0) begin
                    c_pend = 1'b0;
                    if (cmd_idx !== c_idx || cmd_arg !== c_arg || cs_n !== 1'b0) hs_bad++;
                    cmd_done = 1'b1;
                    cmd_r1 = c_r1;
                    cmd_timeout = c_to;
                    if (c_idx == 6'd8 || (c_idx == 6'd41 && m_r8 == 8'h01)) last_end = cyc;
                end
            end
            if (cmd_start) begin
                if (c_pend || cs_n !== 1'b0) hs_bad++;
                if (fast_clk) clk_bad++;
                if (n_cmd < 64) logv[n_cmd] = int'(cmd_idx);
                n_cmd++;
                c_idx = cmd_idx;
                c_arg = cmd_arg;
                c_to = 1'b0;
                c_r1 = 8'h01;
                exp_arg = 32'h0;
                case (cmd_idx)
                    6'd0:  begin c_r1 = m_r0; c_to = m_to0; end
                    6'd8:  begin c_r1 = m_r8; exp_arg = 32'h0000_01AA; end
                    6'd41: begin
                        n_acmd++;
                        c_r1 = (m_ok != 0 && n_acmd >= m_ok) ? 8'h00 : 8'h01;
                        exp_arg = (m_r8 == 8'h01) ? 32'h4000_0000 : 32'h0;
                    end
                    6'd16: begin n_16++; c_r1 = m_r16; exp_arg = 32'd512; end
                    6'd58: begin
                        if (cyc - last_end < min_gap) min_gap = cyc - last_end;
                    end
                    default: c_r1 = 8'h01;
                endcase
                if (cmd_arg !== exp_arg) arg_bad++;
                c_pend = 1'b1;
                c_dly = 2;
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clear_stats();
        clr_req = 1'b1;
        step_n(1);
        clr_req = 1'b0;
    endtask

    task automatic pulse_init();
        @(negedge clk);
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int t;
        t = 0;
        #1;
        while (!init_done && t < 5000) begin
            step_n(1);
            t++;
        end
        chk({tag, " done seen"}, init_done, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin : main
        int path, exp_acmd, exp16;
        string tg;
        step_n(4);
        rst = 1'b0;
        step_n(1);
        // R1 reset state
        chk("R1 card_type", card_type, 0);
        chk("R1 addr_scale", addr_scale, 0);
        chk("R1 fast_clk", fast_clk, 0);
        chk("R1 init_done", init_done, 0);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 requests", {cmd_start, dummy_req}, 0);

        for (int v = 0; v < NV; v++) begin
            tg = $sformatf("R%0d vec%0d", VECS[v].req, v);
            m_r0 = VECS[v].r0; m_r8 = VECS[v].r8; m_r16 = VECS[v].r16;
            m_ok = int'(VECS[v].ok_at); m_to0 = 1'b0;
            clear_stats();
            pulse_init();
            wait_done(tg);
            chk({tg, " card_type"}, card_type, VECS[v].typ);
            chk({tg, " addr_scale"}, addr_scale, VECS[v].scale);
            chk({tg, " R8 fast_clk"}, fast_clk, (VECS[v].typ != 0));
            path = 0;
            if (VECS[v].r0 == 8'h01)
                path = (VECS[v].r8 == 8'h01) ? 2 : (VECS[v].r8 == 8'h05) ? 1 : 0;
            exp_acmd = (path == 0) ? 0 : (VECS[v].ok_at != 0) ? int'(VECS[v].ok_at) : TRIES;
            exp16 = (path != 0 && VECS[v].ok_at != 0) ? 1 : 0;
            chk({tg, " R2 filler count"}, n_dummy, PRE);
            chk({tg, " R2 filler cs/clock"}, dummy_bad, 0);
            chk({tg, " R7 attempts"}, n_acmd, exp_acmd);
            chk({tg, " R8 blklen issued"}, n_16, exp16);
            chk({tg, " R4 arguments"}, arg_bad, 0);
            chk({tg, " R11 handshake"}, hs_bad, 0);
            chk({tg, " R8 slow clock"}, clk_bad, 0);
            chk({tg, " R3 first cmd"}, logv[0], 0);
            if (path != 0) chk({tg, " R4 second cmd"}, logv[1], 8);
            if (path == 2) begin
                chk({tg, " R6 order"}, {logv[2][7:0], logv[3][7:0], logv[4][7:0]}, {8'd58, 8'd55, 8'd41});
                chk({tg, " R6 gap"}, (min_gap >= GAPC), 1);
            end
            if (path == 1)
                chk({tg, " R5 order"}, {logv[2][7:0], logv[3][7:0]}, {8'd55, 8'd41});
            if (exp16 == 1) chk({tg, " R8 last cmd"}, logv[n_cmd - 1], 16);
            step_n(30);
            chk({tg, " R9 pulse count"}, n_done, 1);
            chk({tg, " R9 hold type"}, card_type, VECS[v].typ);
            chk({tg, " R9 done low"}, init_done, 0);
        end

        // R3 timeout on the reset command fails even with an idle byte
        m_r0 = 8'h01; m_r8 = 8'h01; m_ok = 1; m_r16 = 8'h00; m_to0 = 1'b1;
        clear_stats();
        pulse_init();
        wait_done("R3 timeout");
        chk("R3 timeout type", card_type, 0);
        chk("R3 timeout no probe", n_cmd, 1);
        m_to0 = 1'b0;

        // R9 a successful result is cleared when a new request is accepted
        m_r8 = 8'h05; m_ok = 2;
        clear_stats();
        pulse_init();
        wait_done("R9 first");
        chk("R9 first type", card_type, 1);
        clear_stats();
        pulse_init();
        step_n(2);
        chk("R9 cleared type", card_type, 0);
        chk("R9 cleared fast_clk", fast_clk, 0);
        chk("R9 cleared scale", addr_scale, 0);
        wait_done("R9 second");
        chk("R9 second type", card_type, 1);

        // R10 a request in mid-sequence is ignored
        clear_stats();
        pulse_init();
        step_n(10);
        pulse_init();
        wait_done("R10");
        step_n(5);
        chk("R10 filler count", n_dummy, PRE);
        chk("R10 single done", n_done, 1);
        chk("R10 type", card_type, 1);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule